// File: doc/BRIEF.md
# Shared-Pin UART / Paced Parallel Port Controller

This block owns eight interface pins and hands them either to an external UART (transmit, receive and modem control lines), or to an internal 8-bit parallel output port. A mode request input selects the owner. While the parallel port owns the pins, bytes arriving on a valid/ready stream are put on the pins one at a time. At most one byte is taken per pulse of an external divider tick. Each byte carries an 8-bit direction mask: a pin whose mask bit is 0 is released (output enable low), and its level can be read back.

The block also produces the driver-enable signal for an RS485 transceiver while the UART owns the pins. The UART core reports its start bit, the end of its last stop bit, and any break. The enable covers every frame and the whole of a break, so no external delay circuit is needed. A change of owner waits until no UART frame is in flight. The port can go from parallel back to UART at any time without a reset.

Two state machines hold the control. The owner machine has states OWN_UART and OWN_PAR. OWN_UART goes to OWN_PAR on "grant" (request high and no frame busy). OWN_PAR goes to OWN_UART on "release" (request low). The driver-enable machine has states DE_IDLE, DE_FRAME and DE_BREAK. DE_IDLE goes to DE_FRAME on "start", and to DE_BREAK on "brk_on". DE_FRAME goes to DE_IDLE on "stop_done", and to DE_BREAK on "brk_on". DE_BREAK goes to DE_IDLE on "brk_off".

Top module: `pxs_pin_share`

## Requirements
- R1: While reset is held and right after it, the pins are owned by the UART, the parallel data and enable registers are 0, `txen_o` is 0 and `s_ready_o` is 0.
- R2: While `par_mode_o` is 0, `pin_out_o` equals `uart_out_i` and `pin_oe_o` equals `uart_oe_i` in the same cycle.
- R3: A frame counts as busy when any of these holds: `txen_o` is 1, `uart_start_i` is 1, or `uart_rx_busy_i` is 1. With `mode_req_i` at 1 and no frame busy, `par_mode_o` becomes 1 at the next clock edge. While a frame is busy it stays 0.
- R4: `s_ready_o` is 1 only in a cycle where `par_mode_o` is 1 and `pace_tick_i` is 1, so the stream gives up at most one byte per tick. In UART mode it stays 0.
- R5: A byte accepted in cycle n (`s_valid_i` and `s_ready_o` both 1) appears on `pin_out_o` from cycle n+1. `dir_mask_i` of cycle n appears on `pin_oe_o` from cycle n+1.
- R6: In parallel mode, a cycle without an accepted byte leaves `pin_out_o` and `pin_oe_o` unchanged. This covers a tick with no valid byte, and a valid byte with no tick.
- R7: `par_rd_o[i]` is the driven value for a pin whose enable bit is 1. Otherwise it is `pin_in_i[i]` sampled at the previous clock edge.
- R8: With `mode_req_i` at 0 in parallel mode, `par_mode_o` returns to 0 at the next edge, with no reset. The parallel registers keep their values for the next parallel session.
- R9: `txen_o` rises in the cycle after the `uart_start_i` pulse and falls in the cycle after the `uart_stop_i` pulse.
- R10: `txen_o` is 1 in every cycle in which `uart_brk_i` is 1. It stays 1 until the cycle after the break ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_req_i | input | 1 | 1 requests parallel ownership, 0 requests UART ownership |
| pace_tick_i | input | 1 | One-cycle pulse from the external divider |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte taken this cycle if valid |
| dir_mask_i | input | 8 | Per-pin output enable applied with the byte |
| uart_out_i | input | 8 | Pin levels from the UART cores |
| uart_oe_i | input | 8 | Pin enables from the UART cores |
| uart_rx_busy_i | input | 1 | Receiver is inside a frame |
| uart_start_i | input | 1 | Pulse: transmitter begins a start bit |
| uart_stop_i | input | 1 | Pulse: transmitter ends its final stop bit |
| uart_brk_i | input | 1 | Transmitter holds a break |
| pin_in_i | input | 8 | Levels seen on the pins |
| pin_out_o | output | 8 | Level driven on each pin |
| pin_oe_o | output | 8 | Output enable of each pin |
| par_rd_o | output | 8 | Read-back of pin levels in parallel mode |
| par_mode_o | output | 1 | 1 while the parallel port owns the pins |
| txen_o | output | 1 | RS485 driver enable |

## Verification
Some properties are checked on every cycle. Ownership must never change while a frame is busy. Ready must never appear without a tick. An accepted byte and its mask must land on the pins one cycle later, and the pins must stay still in parallel mode when nothing is accepted. The driver enable must be high throughout a break and must drop right after a stop pulse. The exact values only show up in the bench's scenarios: the mapping from pins to stream bytes, the merge of released pins in read-back, the parallel state kept across a return to UART mode, and the exact cycles at which a grant held back by a frame finally happens.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
    typedef enum logic {
        OWN_UART = 1'b0,
        OWN_PAR  = 1'b1
    } own_e;

    typedef enum logic [1:0] {
        DE_IDLE  = 2'd0,
        DE_FRAME = 2'd1,
        DE_BREAK = 2'd2
    } de_e;
endpackage

// File: rtl/pxs_owner_fsm.sv
module pxs_owner_fsm
    import pxs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic frame_busy_i,
    output logic par_o
);
    own_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= OWN_UART;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_UART: if (req_i && !frame_busy_i) st_d = OWN_PAR;   // grant
            OWN_PAR:  if (!req_i)                 st_d = OWN_UART;  // release
            default:  st_d = OWN_UART;
        endcase
    end

    always_comb begin
        par_o = (st_q == OWN_PAR);
    end
endmodule

// File: rtl/pxs_de_fsm.sv
module pxs_de_fsm
    import pxs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic stop_i,
    input  logic brk_i,
    output logic de_o
);
    de_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= DE_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DE_IDLE: begin
                if (brk_i)        st_d = DE_BREAK;  // brk_on
                else if (start_i) st_d = DE_FRAME;  // start
            end
            DE_FRAME: begin
                if (brk_i)        st_d = DE_BREAK;  // brk_on
                else if (stop_i)  st_d = DE_IDLE;   // stop_done
            end
            DE_BREAK: if (!brk_i) st_d = DE_IDLE;   // brk_off
            default:  st_d = DE_IDLE;
        endcase
    end

    // The break level enables the driver in the same cycle; the state holds
    // it one cycle past the break.
    always_comb begin
        de_o = (st_q != DE_IDLE) || brk_i;
    end
endmodule

// File: rtl/pxs_par_port.sv
module pxs_par_port #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] pin_in_i,
    output logic         ready_o,
    output logic [W-1:0] drv_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] rd_o
);
    logic [W-1:0] drv_q, oe_q, in_q;
    logic         take;

    always_comb begin
        ready_o = en_i && tick_i;
        take    = ready_o && valid_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            drv_q <= '0;
            oe_q  <= '0;
            in_q  <= '0;
        end else begin
            in_q <= pin_in_i;
            if (take) begin
                drv_q <= data_i;
                oe_q  <= mask_i;
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_rd
        assign rd_o[i] = oe_q[i] ? drv_q[i] : in_q[i];
    end

    assign drv_o = drv_q;
    assign oe_o  = oe_q;
endmodule

// File: rtl/pxs_pin_share.sv
module pxs_pin_share #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         mode_req_i,
    input  logic         pace_tick_i,
    input  logic         s_valid_i,
    input  logic [W-1:0] s_data_i,
    output logic         s_ready_o,
    input  logic [W-1:0] dir_mask_i,
    input  logic [W-1:0] uart_out_i,
    input  logic [W-1:0] uart_oe_i,
    input  logic         uart_rx_busy_i,
    input  logic         uart_start_i,
    input  logic         uart_stop_i,
    input  logic         uart_brk_i,
    input  logic [W-1:0] pin_in_i,
    output logic [W-1:0] pin_out_o,
    output logic [W-1:0] pin_oe_o,
    output logic [W-1:0] par_rd_o,
    output logic         par_mode_o,
    output logic         txen_o
);
    logic         par_mode, de, frame_busy;
    logic [W-1:0] par_drv, par_oe;

    assign frame_busy = de || uart_start_i || uart_rx_busy_i;

    pxs_owner_fsm u_owner (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (mode_req_i),
        .frame_busy_i (frame_busy),
        .par_o        (par_mode)
    );

    pxs_de_fsm u_de (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (uart_start_i),
        .stop_i  (uart_stop_i),
        .brk_i   (uart_brk_i),
        .de_o    (de)
    );

    pxs_par_port #(.W(W)) u_par (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (par_mode),
        .tick_i   (pace_tick_i),
        .valid_i  (s_valid_i),
        .data_i   (s_data_i),
        .mask_i   (dir_mask_i),
        .pin_in_i (pin_in_i),
        .ready_o  (s_ready_o),
        .drv_o    (par_drv),
        .oe_o     (par_oe),
        .rd_o     (par_rd_o)
    );

    always_comb begin
        pin_out_o = par_mode ? par_drv : uart_out_i;
        pin_oe_o  = par_mode ? par_oe  : uart_oe_i;
    end

    assign par_mode_o = par_mode;
    assign txen_o     = de;
endmodule

// File: rtl/pxs_pin_share_chk.sv
module pxs_pin_share_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         mode_req_i,
    input logic         pace_tick_i,
    input logic         s_valid_i,
    input logic [W-1:0] s_data_i,
    input logic         s_ready_o,
    input logic [W-1:0] dir_mask_i,
    input logic         uart_rx_busy_i,
    input logic         uart_start_i,
    input logic         uart_stop_i,
    input logic         uart_brk_i,
    input logic [W-1:0] pin_out_o,
    input logic [W-1:0] pin_oe_o,
    input logic         par_mode_o,
    input logic         txen_o
);
    // R3: ownership is granted only after a cycle with no frame busy
    a_r3_no_grant_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(par_mode_o) |-> $past(mode_req_i && !txen_o && !uart_start_i && !uart_rx_busy_i));

    // R4: ready never appears without a tick and parallel ownership
    a_r4_ready_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ready_o |-> (pace_tick_i && par_mode_o));

    // R5: accepted byte and mask reach the pins on the next cycle
    a_r5_byte_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_valid_i && s_ready_o && mode_req_i) |=>
            (pin_out_o == $past(s_data_i) && pin_oe_o == $past(dir_mask_i)));

    // R6: pins hold in parallel mode when nothing is accepted
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (par_mode_o && mode_req_i && !(s_valid_i && s_ready_o)) |=>
            ($stable(pin_out_o) && $stable(pin_oe_o)));

    // R9: enable drops right after the stop pulse
    a_r9_drop_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uart_stop_i && !uart_start_i && !uart_brk_i) |=> (txen_o == uart_brk_i));

    // R10: break always enables the driver
    a_r10_break_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uart_brk_i |-> txen_o);
endmodule

bind pxs_pin_share pxs_pin_share_chk #(.W(W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_req_i     (mode_req_i),
    .pace_tick_i    (pace_tick_i),
    .s_valid_i      (s_valid_i),
    .s_data_i       (s_data_i),
    .s_ready_o      (s_ready_o),
    .dir_mask_i     (dir_mask_i),
    .uart_rx_busy_i (uart_rx_busy_i),
    .uart_start_i   (uart_start_i),
    .uart_stop_i    (uart_stop_i),
    .uart_brk_i     (uart_brk_i),
    .pin_out_o      (pin_out_o),
    .pin_oe_o       (pin_oe_o),
    .par_mode_o     (par_mode_o),
    .txen_o         (txen_o)
);

// File: tb/pxs_pin_share_tb_top.sv
module pxs_pin_share_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_req, tick, s_valid, s_ready;
    logic [7:0] s_data, dir_mask, uart_out, uart_oe, pin_in;
    logic       rx_busy, u_start, u_stop, u_brk;
    logic [7:0] pin_out, pin_oe, par_rd;
    logic       par_mode, txen;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pxs_pin_share dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode_req), .pace_tick_i(tick),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
        .dir_mask_i(dir_mask), .uart_out_i(uart_out), .uart_oe_i(uart_oe),
        .uart_rx_busy_i(rx_busy), .uart_start_i(u_start), .uart_stop_i(u_stop),
        .uart_brk_i(u_brk), .pin_in_i(pin_in), .pin_out_o(pin_out),
        .pin_oe_o(pin_oe), .par_rd_o(par_rd), .par_mode_o(par_mode), .txen_o(txen)
    );

    // {tick, valid, data, mask, exp_out, exp_oe}
    localparam logic [33:0] VECS [6] = '{
        {1'b1, 1'b1, 8'hA5, 8'hFF, 8'hA5, 8'hFF},
        {1'b0, 1'b1, 8'h3C, 8'h0F, 8'hA5, 8'hFF},
        {1'b1, 1'b0, 8'h3C, 8'h0F, 8'hA5, 8'hFF},
        {1'b1, 1'b1, 8'h3C, 8'h0F, 8'h3C, 8'h0F},
        {1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b1, 8'hFF, 8'h80, 8'hFF, 8'h80}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; mode_req = 0; tick = 1; s_valid = 1; s_data = 8'h11; dir_mask = 8'hFF;
        uart_out = 8'h5A; uart_oe = 8'hC3; pin_in = 8'h00;
        rx_busy = 0; u_start = 0; u_stop = 0; u_brk = 0;
        nxt(); nxt();
        // R1 reset state
        chk("R1 par_mode", par_mode, 0);
        chk("R1 txen", txen, 0);
        chk("R1 ready", s_ready, 0);
        chk("R2 out in reset", pin_out, 8'h5A);
        rst_n = 1; tick = 0; s_valid = 0;
        nxt();
        chk("R1 par_rd after reset", par_rd, 8'h00);
        // R2 pass-through, same cycle
        uart_out = 8'h96; uart_oe = 8'h0F; #1;
        chk("R2 out", pin_out, 8'h96);
        chk("R2 oe", pin_oe, 8'h0F);
        tick = 1; #1;
        chk("R4 no ready in uart mode", s_ready, 0);
        tick = 0;
        // R3 grant held by receiver
        rx_busy = 1; mode_req = 1;
        nxt(); nxt(); nxt();
        chk("R3 held by rx", par_mode, 0);
        rx_busy = 0;
        nxt();
        chk("R3 granted", par_mode, 1);
        chk("R1 par regs zero out", pin_out, 8'h00);
        chk("R1 par regs zero oe", pin_oe, 8'h00);
        // Vector table, R4 R5 R6
        for (int k = 0; k < 6; k++) begin
            tick = VECS[k][33]; s_valid = VECS[k][32];
            s_data = VECS[k][31:24]; dir_mask = VECS[k][23:16];
            #1;
            chk($sformatf("R4 ready vec%0d", k), s_ready, VECS[k][33]);
            nxt();
            tick = 0; s_valid = 0;
            chk($sformatf("R5/R6 out vec%0d", k), pin_out, VECS[k][15:8]);
            chk($sformatf("R5/R6 oe vec%0d", k), pin_oe, VECS[k][7:0]);
        end
        // R7 read-back: mask 0F, data A5, pins 3C
        tick = 1; s_valid = 1; s_data = 8'hA5; dir_mask = 8'h0F; pin_in = 8'h3C;
        nxt();
        tick = 0; s_valid = 0;
        chk("R7 readback merge", par_rd, 8'h35);
        pin_in = 8'hC0;
        nxt();
        chk("R7 readback follows pins", par_rd, 8'hC5);
        // R8 return to UART without reset
        uart_out = 8'h77; uart_oe = 8'hFF; mode_req = 0;
        #1;
        chk("R8 still parallel before edge", pin_out, 8'hA5);
        nxt();
        chk("R8 back to uart", par_mode, 0);
        chk("R8 uart pins", pin_out, 8'h77);
        mode_req = 1;
        nxt();
        chk("R8 retained out", pin_out, 8'hA5);
        chk("R8 retained oe", pin_oe, 8'h0F);
        mode_req = 0;
        nxt();
        // R9 frame
        u_start = 1; #1;
        chk("R9 not before start edge", txen, 0);
        nxt();
        u_start = 0;
        chk("R9 rise after start", txen, 1);
        mode_req = 1;
        nxt(); nxt();
        chk("R3 held by tx frame", par_mode, 0);
        u_stop = 1;
        nxt();
        u_stop = 0;
        chk("R9 fall after stop", txen, 0);
        chk("R3 not yet granted", par_mode, 0);
        nxt();
        chk("R3 granted after frame", par_mode, 1);
        mode_req = 0;
        nxt();
        // R10 break
        u_brk = 1; #1;
        chk("R10 break same cycle", txen, 1);
        nxt(); nxt();
        chk("R10 break held", txen, 1);
        u_brk = 0; #1;
        chk("R10 held at break end", txen, 1);
        nxt();
        chk("R10 fall after break", txen, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule